// File: doc/BRIEF.md
# Weighted Priority Port Arbiter

This block decides which of up to six client ports may place the next command on a single shared memory command channel. Each port has a static priority level and a static five-bit weight. At each decision only the ports requesting at the highest requested priority level take part. Within that level, grants are spread in proportion to the weights. A per-port credit counter is loaded with the port's weight at the start of each round, and each accepted grant uses one credit.

A grant is issued as a one-hot vector together with its binary index. It stays fixed until the downstream controller pulses an accept strobe. Credits and the rotating tie-break pointer change only on that accept. The clock edge after an accept returns the arbiter to idle, and the edge after that makes the next decision. This gives at most one grant every two cycles.

Top module: `port_share_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every credit, sets the rotating pointer to 0 and drives `grant` to all zeros and `grant_idx` to 0. `grant_idx` reads 0 whenever `grant` is zero.
- R2: `grant` has at most one bit set. When it is nonzero, `grant_idx` is the position of that bit, and that port was requesting in the cycle the decision was made.
- R3: Priority of port i is `prio_cfg[i*PRIO_W +: PRIO_W]`, and a larger value wins. A new grant always goes to a port at the highest priority among the ports requesting in the decision cycle.
- R4: Weight of port i is `weight_cfg[i*5 +: 5]` (0 to 31). When ports at the same priority all keep requesting, each round gives port i exactly its weight in grants. For example, weights 4 and 6 give 8 and 12 of 20 grants.
- R5: A new round begins when no requesting port of the winning level has credit left and at least one of them has a nonzero weight. Only those requesting ports are reloaded to their weights, and the reload takes effect with the accept of that grant.
- R6: A port with weight 0 is granted only when no requesting port at its level has a nonzero weight. Such ports then take turns in rotating order.
- R7: Among eligible ports, the search starts at the port after the last accepted index and wraps around. After reset the first search begins at port 1.
- R8: A nonzero grant holds unchanged while `accept` is low. The edge that samples `accept` high clears the grant. A new decision is made only from the idle state.
- R9: A port that withdraws its request keeps its unused credit. It spends that credit when it requests again, unless a reload of the ports still requesting happens in between.
- R10: With no request present, `grant` stays all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NPORTS | Per-port request lines |
| prio_cfg | input | NPORTS*PRIO_W | Packed per-port priority levels |
| weight_cfg | input | NPORTS*WEIGHT_W | Packed per-port weights |
| accept | input | 1 | Downstream controller takes the current grant |
| grant | output | NPORTS | One-hot grant, zero when idle |
| grant_idx | output | IDX_W | Index of the granted port, 0 when idle |

## Verification
A bad credit count shows up within one round as a grant sequence whose per-port totals drift from the weights. This is visible at most about twice the sum of the level's weights in cycles after the fault. A corrupted pointer changes which port is named on the very next decision among tied ports. A wrong reload mask shows up as a withdrawn port losing its leftover credit, or as a zero-weight port being served ahead of a weighted one. The scoreboard runs an independent model of credits and pointer and compares every grant against it, so each of these faults is reported at the first grant it alters.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int MAX_PORTS    = 6;
  localparam int DEF_PRIO_W   = 3;
  localparam int DEF_WEIGHT_W = 5;

  // Index width for a given port count, never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Arbiter sequencing: idle (deciding) or holding a grant.
  typedef enum logic {ARB_IDLE = 1'b0, ARB_HOLD = 1'b1} arb_state_e;
endpackage

// File: rtl/psa_class_sel.sv
module psa_class_sel #(
  parameter int NPORTS = 6,
  parameter int PRIO_W = 3
) (
  input  logic [NPORTS-1:0]        req,
  input  logic [NPORTS*PRIO_W-1:0] prio_cfg,
  output logic [NPORTS-1:0]        level_req,
  output logic                     any_req
);
  logic [PRIO_W-1:0] top_lvl;

  function automatic logic [PRIO_W-1:0] lvl_of(input logic [NPORTS*PRIO_W-1:0] f, input int i);
    return f[i*PRIO_W +: PRIO_W];
  endfunction

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (req[i] && (lvl_of(prio_cfg, i) > top_lvl)) top_lvl = lvl_of(prio_cfg, i);
    end
  end

  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      level_req[i] = req[i] && (lvl_of(prio_cfg, i) == top_lvl);
    end
  end

  assign any_req = |req;
endmodule

// File: rtl/psa_rr_pick.sv
module psa_rr_pick #(
  parameter int NPORTS = 6,
  parameter int IDX_W  = 3
) (
  input  logic [NPORTS-1:0] cand,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              found,
  output logic [IDX_W-1:0]  pick_idx
);
  // Wrapping successor of base by k positions.
  function automatic int wrap_step(input int base, input int k);
    int s;
    s = base + k;
    if (s >= NPORTS) s = s - NPORTS;
    return s;
  endfunction

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= NPORTS; k++) begin
      if (!found && cand[wrap_step(int'(last_idx), k)]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(wrap_step(int'(last_idx), k));
      end
    end
  end
endmodule

// File: rtl/psa_credit_bank.sv
module psa_credit_bank #(
  parameter int NPORTS   = 6,
  parameter int WEIGHT_W = 5,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit,
  input  logic                       reload,
  input  logic [NPORTS-1:0]          reload_mask,
  input  logic [IDX_W-1:0]           used_idx,
  input  logic [NPORTS*WEIGHT_W-1:0] weight_cfg,
  output logic [NPORTS-1:0]          credit_nz,
  output logic [NPORTS-1:0]          weight_nz
);
  // Credit after an accepted grant: optional reload, then one spent by the winner.
  function automatic logic [WEIGHT_W-1:0] next_credit(
    input logic [WEIGHT_W-1:0] cur, input logic [WEIGHT_W-1:0] wgt,
    input logic do_load, input logic is_winner);
    logic [WEIGHT_W-1:0] base;
    base = do_load ? wgt : cur;
    if (is_winner && (base != '0)) base = base - 1'b1;
    return base;
  endfunction

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic [WEIGHT_W-1:0] cr_q;
    logic [WEIGHT_W-1:0] wgt;
    logic                is_win;

    assign wgt    = weight_cfg[g*WEIGHT_W +: WEIGHT_W];
    assign is_win = (used_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) cr_q <= '0;
      else if (commit) cr_q <= next_credit(cr_q, wgt, reload && reload_mask[g], is_win);
    end

    assign credit_nz[g] = (cr_q != '0);
    assign weight_nz[g] = (wgt != '0);
  end
endmodule

// File: rtl/port_share_arbiter.sv
module port_share_arbiter #(
  parameter int NPORTS   = psa_pkg::MAX_PORTS,
  parameter int PRIO_W   = psa_pkg::DEF_PRIO_W,
  parameter int WEIGHT_W = psa_pkg::DEF_WEIGHT_W,
  localparam int IDX_W   = psa_pkg::idx_bits(NPORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPORTS-1:0]          req,
  input  logic [NPORTS*PRIO_W-1:0]   prio_cfg,
  input  logic [NPORTS*WEIGHT_W-1:0] weight_cfg,
  input  logic                       accept,
  output logic [NPORTS-1:0]          grant,
  output logic [IDX_W-1:0]           grant_idx
);
  import psa_pkg::*;

  arb_state_e         state_q;
  logic [NPORTS-1:0]  gnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   ptr_q;
  logic               reload_q;
  logic [NPORTS-1:0]  rmask_q;

  // Named internal events.
  logic               ev_decide;
  logic               ev_commit;
  logic               ev_reload;
  logic [NPORTS-1:0]  level_req;
  logic               any_req;
  logic [NPORTS-1:0]  credit_nz;
  logic [NPORTS-1:0]  weight_nz;
  logic [NPORTS-1:0]  weighted_set;
  logic [NPORTS-1:0]  pick_set;
  logic               pick_found;
  logic [IDX_W-1:0]   pick_idx;

  psa_class_sel #(.NPORTS(NPORTS), .PRIO_W(PRIO_W)) u_class (
    .req       (req),
    .prio_cfg  (prio_cfg),
    .level_req (level_req),
    .any_req   (any_req)
  );

  psa_credit_bank #(.NPORTS(NPORTS), .WEIGHT_W(WEIGHT_W), .IDX_W(IDX_W)) u_credit (
    .clk         (clk),
    .rst         (rst),
    .commit      (ev_commit),
    .reload      (reload_q),
    .reload_mask (rmask_q),
    .used_idx    (idx_q),
    .weight_cfg  (weight_cfg),
    .credit_nz   (credit_nz),
    .weight_nz   (weight_nz)
  );

  // New round when the contenders hold no credit but some can earn it.
  assign ev_reload    = ((level_req & credit_nz) == '0) && ((level_req & weight_nz) != '0);
  assign weighted_set = level_req & (ev_reload ? weight_nz : credit_nz);
  assign pick_set     = (weighted_set != '0) ? weighted_set : level_req;

  psa_rr_pick #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_pick (
    .cand     (pick_set),
    .last_idx (ptr_q),
    .found    (pick_found),
    .pick_idx (pick_idx)
  );

  assign ev_decide = (state_q == ARB_IDLE) && any_req && pick_found;
  assign ev_commit = (state_q == ARB_HOLD) && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      gnt_q    <= '0;
      idx_q    <= '0;
      ptr_q    <= '0;
      reload_q <= 1'b0;
      rmask_q  <= '0;
    end else if (ev_decide) begin
      state_q  <= ARB_HOLD;
      gnt_q    <= NPORTS'(1) << pick_idx;
      idx_q    <= pick_idx;
      reload_q <= ev_reload;
      rmask_q  <= level_req;
    end else if (ev_commit) begin
      state_q  <= ARB_IDLE;
      gnt_q    <= '0;
      idx_q    <= '0;
      ptr_q    <= idx_q;
      reload_q <= 1'b0;
      rmask_q  <= '0;
    end
  end

  assign grant     = gnt_q;
  assign grant_idx = idx_q;
endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int NPORTS = 6,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPORTS-1:0]        req,
  input logic [NPORTS*PRIO_W-1:0] prio_cfg,
  input logic                     accept,
  input logic [NPORTS-1:0]        grant,
  input logic [IDX_W-1:0]         grant_idx
);
  logic [NPORTS-1:0] req_q;
  logic [NPORTS-1:0] gnt_prev;
  logic [PRIO_W-1:0] top_now;
  logic [PRIO_W-1:0] top_q;
  logic [PRIO_W-1:0] gnt_lvl;
  logic              fresh;

  always_comb begin
    top_now = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (req[i] && (prio_cfg[i*PRIO_W +: PRIO_W] > top_now)) top_now = prio_cfg[i*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    gnt_lvl = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (grant_idx == IDX_W'(i)) gnt_lvl = prio_cfg[i*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      gnt_prev <= '0;
      top_q    <= '0;
    end else begin
      req_q    <= req;
      gnt_prev <= grant;
      top_q    <= top_now;
    end
  end

  assign fresh = (grant != '0) && (gnt_prev == '0);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (grant == '0) && (grant_idx == '0)); // R1
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (rst) (grant == '0) |-> (grant_idx == '0)); // R1
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R2
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst) (grant != '0) |-> grant[grant_idx]); // R2
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (rst) fresh |-> req_q[grant_idx]); // R2
  AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (rst) fresh |-> (gnt_lvl == top_q)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) ((grant != '0) && !accept) |=> $stable(grant)); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst) ((grant != '0) && accept) |=> (grant == '0)); // R8
  AST_NO_REQ: assert property (@(posedge clk) disable iff (rst) ((grant == '0) && (req == '0)) |=> (grant == '0)); // R10
endmodule

bind port_share_arbiter psa_checker #(.NPORTS(NPORTS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .prio_cfg  (prio_cfg),
  .accept    (accept),
  .grant     (grant),
  .grant_idx (grant_idx)
);

// File: tb/port_share_arbiter_tb_top.sv
module port_share_arbiter_tb_top;
  localparam int N  = 6;
  localparam int PW = 3;
  localparam int WW = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N*PW-1:0] prio_cfg = '0;
  logic [N*WW-1:0] weight_cfg = '0;
  logic          accept = 1'b0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R2";

  int exp_q[$];
  int obs_cnt[N];
  logic [N-1:0] prev_gnt = '0;

  // Independent reference state.
  int m_prio[N];
  int m_w[N];
  int m_cr[N];
  int m_ptr;

  always #10 clk = ~clk;

  port_share_arbiter #(.NPORTS(N), .PRIO_W(PW), .WEIGHT_W(WW)) dut_i (
    .clk(clk), .rst(rst), .req(req), .prio_cfg(prio_cfg), .weight_cfg(weight_cfg),
    .accept(accept), .grant(grant), .grant_idx(grant_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic set_port(input int i, input int p, input int w);
    prio_cfg[i*PW +: PW]   = PW'(p);
    weight_cfg[i*WW +: WW] = WW'(w);
    m_prio[i] = p;
    m_w[i]    = w;
  endtask

  task automatic do_reset();
    req = '0;
    accept = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) m_cr[i] = 0;
    m_ptr = 0;
    prev_gnt = '0;
  endtask

  // Reference decision from the stated rules.
  task automatic model_pick(output int idx, output bit rl, output bit [N-1:0] msk);
    int top;
    bit any_cr, any_w, done;
    top = -1; any_cr = 0; any_w = 0; done = 0; idx = -1; msk = '0;
    for (int i = 0; i < N; i++) if (req[i] && m_prio[i] > top) top = m_prio[i];
    for (int i = 0; i < N; i++) if (req[i] && m_prio[i] == top) msk[i] = 1'b1;
    for (int i = 0; i < N; i++) if (msk[i]) begin
      if (m_cr[i] > 0) any_cr = 1;
      if (m_w[i] > 0) any_w = 1;
    end
    rl = !any_cr && any_w;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (m_ptr + k) % N;
      if (!done && msk[j] && ((rl ? m_w[j] : m_cr[j]) > 0)) begin idx = j; done = 1; end
    end
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (m_ptr + k) % N;
      if (!done && msk[j]) begin idx = j; done = 1; end
    end
  endtask

  task automatic model_commit(input int idx, input bit rl, input bit [N-1:0] msk);
    if (rl) for (int i = 0; i < N; i++) if (msk[i]) m_cr[i] = m_w[i];
    if (m_cr[idx] > 0) m_cr[idx]--;
    m_ptr = idx;
  endtask

  // Driver: one grant, optionally held for some cycles before accept.
  task automatic serve(input int hold);
    int idx;
    bit rl;
    bit [N-1:0] msk;
    logic [N-1:0] snap;
    model_pick(idx, rl, msk);
    exp_q.push_back(idx);
    do @(negedge clk); while (grant == '0);
    snap = grant;
    for (int c = 0; c < hold; c++) begin
      @(negedge clk);
      check(grant == snap, "R8", int'(grant), int'(snap));
    end
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    model_commit(idx, rl, msk);
    check(grant == '0, "R8", int'(grant), 0);
  endtask

  task automatic serve_n(input int n);
    for (int s = 0; s < n; s++) serve(0);
  endtask

  // Monitor: compare each new grant with the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (grant != '0 && prev_gnt == '0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, int'(grant_idx), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(grant_idx) == e, cur_tag, int'(grant_idx), e);
          check(grant == (N'(1) << e), "R2", int'(grant), 1 << e);
          obs_cnt[grant_idx]++;
        end
      end
      prev_gnt = grant;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic clear_counts();
    for (int i = 0; i < N; i++) obs_cnt[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) set_port(i, 0, 1);
    do_reset();
    // R1: reset state at the ports
    check(grant == '0, "R1", int'(grant), 0);
    check(grant_idx == '0, "R1", int'(grant_idx), 0);

    // R7: first search after reset begins at port 1
    cur_tag = "R7";
    req = '1;
    serve(0);
    req = '0;
    serve_n(0);

    // R8: grant held while accept is low
    cur_tag = "R8";
    req = 6'b000100;
    serve(4);
    req = '0;

    // R10: no request, no grant
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(grant == '0, "R10", int'(grant), 0);
    end

    // R3: highest requested level served first
    set_port(0, 1, 2); set_port(1, 1, 2); set_port(2, 4, 2);
    set_port(3, 4, 2); set_port(4, 2, 2); set_port(5, 0, 2);
    do_reset();
    cur_tag = "R3";
    clear_counts();
    req = '1;
    serve_n(8);
    req = 6'b110011;
    serve_n(4);
    req = '0;
    check(obs_cnt[2] + obs_cnt[3] == 8, "R3", obs_cnt[2] + obs_cnt[3], 8);
    check(obs_cnt[4] == 4, "R3", obs_cnt[4], 4);

    // R4 / R5: weights 4 and 6 share 20 grants as 8 and 12
    for (int i = 0; i < N; i++) set_port(i, 0, 7);
    set_port(1, 5, 4); set_port(3, 5, 6);
    do_reset();
    cur_tag = "R4";
    clear_counts();
    req = '1;
    serve_n(20);
    req = '0;
    check(obs_cnt[1] == 8, "R4", obs_cnt[1], 8);
    check(obs_cnt[3] == 12, "R4", obs_cnt[3], 12);
    check(obs_cnt[0] + obs_cnt[5] == 0, "R5", obs_cnt[0] + obs_cnt[5], 0);

    // R6: zero-weight ports wait behind a weighted peer, then rotate
    for (int i = 0; i < N; i++) set_port(i, 2, 5);
    set_port(0, 2, 0); set_port(2, 2, 3); set_port(4, 2, 0);
    do_reset();
    cur_tag = "R6";
    clear_counts();
    req = 6'b010101;
    serve_n(6);
    check(obs_cnt[2] == 6, "R6", obs_cnt[2], 6);
    req = 6'b010001;
    serve_n(4);
    req = '0;
    check(obs_cnt[0] == 2 && obs_cnt[4] == 2, "R6", obs_cnt[0], 2);

    // R9: withdrawn port keeps unused credit
    for (int i = 0; i < N; i++) set_port(i, 0, 0);
    set_port(0, 3, 3); set_port(1, 3, 3);
    do_reset();
    cur_tag = "R9";
    clear_counts();
    req = 6'b000011;
    serve_n(3);
    req = 6'b000010;
    serve_n(3);
    req = 6'b000011;
    serve_n(5);
    req = '0;
    check(obs_cnt[0] == 4, "R9", obs_cnt[0], 4);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule